// File: doc/BRIEF.md
# Byte-Wide Double-Buffered Dual DAC Loader

This block is the digital front end of a two-channel 12-bit converter that is fed from an 8-bit host bus. Each channel keeps a 12-bit holding word, which the host fills in two pieces: an 8-bit low part and a 4-bit high part. A two-bit address picks which of the four pieces a bus write targets. Writes need chip-select and write, both active low. The holding words never reach the outputs directly.

A separate active-low update strobe, qualified by chip-select, copies both holding words into the two output code registers on the same clock edge, so both channels change together. An active-low clear zeroes every register at once without waiting for a clock. All strobes are sampled on the rising edge of `clk`. While a write condition is held, the target piece follows the bus on every edge, and the last sampled value stays.

Top module: `dual_dac_loader`

## Requirements
- R1: While `clr_n` is low, both holding words and both output codes are zero, and the outputs go to zero without waiting for a clock edge.
- R2: A write with `addr`=0 (cs_n=0, wr_n=0 at a rising edge) loads `data[7:0]` into bits 7..0 of the channel A holding word and leaves bits 11..8 unchanged.
- R3: A write with `addr`=1 loads `data[3:0]` into bits 11..8 of the channel A holding word; `data[7:4]` is ignored and bits 7..0 are unchanged.
- R4: `addr`=2 targets bits 7..0 and `addr`=3 targets bits 11..8 of the channel B holding word, with the same bus bits as for channel A; channel A is untouched.
- R5: No holding word changes at an edge where `cs_n` or `wr_n` is high.
- R6: The outputs `dac_a` and `dac_b` change only at an edge where both `cs_n` and `upd_n` are low.
- R7: An update (cs_n=0, upd_n=0 at a rising edge) copies both holding words into `dac_a` and `dac_b` on that same edge.
- R8: `upd_n` low while `cs_n` is high has no effect on the outputs.
- R9: When a write and an update are sampled on the same edge, the outputs take the holding words including the newly written piece.
- R10: While a write condition is held over several edges, the target piece follows the bus on each edge, and the value on the bus at the last such edge is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes are sampled on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| cs_n | input | 1 | Chip-select, active low |
| wr_n | input | 1 | Write strobe, active low |
| upd_n | input | 1 | Update strobe, active low, qualified by cs_n |
| addr | input | 2 | Piece select: 0 A low, 1 A high, 2 B low, 3 B high |
| data | input | 8 | Host data bus |
| dac_a | output | 12 | Channel A output code |
| dac_b | output | 12 | Channel B output code |

## Verification
The bench writes the four pieces in a shuffled order and checks after each write that the outputs have not moved. A design that passed holding data straight to the outputs, or that updated one channel at a time, fails this check. Nibble writes carry ones in bus bits 7..4. A decoder that took the wrong bus bits would leak those ones into bits 11..8 or overwrite the low byte. The bench also covers an update with chip-select high, which a design that ignored chip-select on update would act on. It covers a write and an update on the same edge, which a design that copied the old holding value would get wrong. A held write with a changing bus checks that the last value wins. A clear asserted between edges checks that the outputs drop at once and that the holding words are zeroed too.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        SEL_A_LO = 2'd0,
        SEL_A_HI = 2'd1,
        SEL_B_LO = 2'd2,
        SEL_B_HI = 2'd3
    } piece_sel_e;

    typedef struct packed {
        logic lo_en;
        logic hi_en;
    } part_en_t;

    function automatic int unsigned chan_of(piece_sel_e sel);
        return int'(sel[1]);
    endfunction

    function automatic logic is_high_part(piece_sel_e sel);
        return sel[0];
    endfunction

endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
    import dac_if_pkg::*;
(
    input  logic                    cs_n,
    input  logic                    wr_n,
    input  logic [1:0]              addr,
    output part_en_t [NUM_CH-1:0]   part_en
);

    piece_sel_e sel;
    logic       wr_act;

    assign sel    = piece_sel_e'(addr);
    assign wr_act = !cs_n && !wr_n;

    always_comb begin
        part_en = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (wr_act && chan_of(sel) == ch) begin
                part_en[ch].lo_en = !is_high_part(sel);
                part_en[ch].hi_en =  is_high_part(sel);
            end
        end
    end

endmodule

// File: rtl/dac_hold_reg.sv
module dac_hold_reg
    import dac_if_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              clr_n,
    input  part_en_t          en,
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] hold_d,
    output logic [CODE_W-1:0] hold_q
);

    localparam int LO_W = DATA_W;
    localparam int HI_W = CODE_W - DATA_W;

    always_comb begin
        hold_d = hold_q;
        if (en.lo_en) hold_d[LO_W-1:0]      = data;
        if (en.hi_en) hold_d[CODE_W-1:LO_W] = data[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

endmodule

// File: rtl/dac_out_reg.sv
module dac_out_reg
    import dac_if_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                           clk,
    input  logic                           clr_n,
    input  logic                           load,
    input  logic [NUM_CH-1:0][CODE_W-1:0]  d,
    output logic [NUM_CH-1:0][CODE_W-1:0]  q
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)    q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dac_if_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              upd_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] dac_a,
    output logic [CODE_W-1:0] dac_b
);

    part_en_t [NUM_CH-1:0]          part_en;
    logic [NUM_CH-1:0][CODE_W-1:0]  hold_d;
    logic [NUM_CH-1:0][CODE_W-1:0]  hold_q;
    logic [NUM_CH-1:0][CODE_W-1:0]  code_q;
    logic                           upd_act;

    dac_wr_decode u_dec (
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .part_en (part_en)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hold
        dac_hold_reg #(
            .DATA_W (DATA_W),
            .CODE_W (CODE_W)
        ) u_hold (
            .clk    (clk),
            .clr_n  (clr_n),
            .en     (part_en[ch]),
            .data   (data),
            .hold_d (hold_d[ch]),
            .hold_q (hold_q[ch])
        );
    end

    assign upd_act = !cs_n && !upd_n;

    // Loading from hold_d lets a write on the update edge reach the outputs.
    dac_out_reg #(
        .CODE_W (CODE_W)
    ) u_out (
        .clk   (clk),
        .clr_n (clr_n),
        .load  (upd_act),
        .d     (hold_d),
        .q     (code_q)
    );

    assign dac_a = code_q[0];
    assign dac_b = code_q[1];

endmodule

// File: rtl/dual_dac_loader_chk.sv
module dual_dac_loader_chk
    import dac_if_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CODE_W = 12
) (
    input logic                          clk,
    input logic                          clr_n,
    input logic                          cs_n,
    input logic                          wr_n,
    input logic                          upd_n,
    input logic [1:0]                    addr,
    input logic [DATA_W-1:0]             data,
    input logic [CODE_W-1:0]             dac_a,
    input logic [CODE_W-1:0]             dac_b,
    input logic [NUM_CH-1:0][CODE_W-1:0] hold_q
);

    localparam int LO_W = DATA_W;
    localparam int HI_W = CODE_W - DATA_W;

    // R1
    always @(negedge clk) begin
        if (!clr_n) begin
            a_r1_clear_zero: assert (dac_a == '0 && dac_b == '0 && hold_q == '0);
        end
    end

    a_r2_a_low: assert property (@(posedge clk) disable iff (!clr_n)
        (!cs_n && !wr_n && addr == 2'd0) |=>
        (hold_q[0][LO_W-1:0] == $past(data) &&
         hold_q[0][CODE_W-1:LO_W] == $past(hold_q[0][CODE_W-1:LO_W])));

    a_r3_a_high: assert property (@(posedge clk) disable iff (!clr_n)
        (!cs_n && !wr_n && addr == 2'd1) |=>
        (hold_q[0][CODE_W-1:LO_W] == $past(data[HI_W-1:0]) &&
         hold_q[0][LO_W-1:0] == $past(hold_q[0][LO_W-1:0])));

    a_r4_b_only: assert property (@(posedge clk) disable iff (!clr_n)
        (!cs_n && !wr_n && addr[1]) |=> $stable(hold_q[0]));

    a_r5_no_write: assert property (@(posedge clk) disable iff (!clr_n)
        (cs_n || wr_n) |=> $stable(hold_q));

    a_r6_out_hold: assert property (@(posedge clk) disable iff (!clr_n)
        !(!cs_n && !upd_n) |=> ($stable(dac_a) && $stable(dac_b)));

    a_r7_update: assert property (@(posedge clk) disable iff (!clr_n)
        (!cs_n && !upd_n && wr_n) |=> ({dac_b, dac_a} == $past(hold_q)));

    a_r8_upd_needs_cs: assert property (@(posedge clk) disable iff (!clr_n)
        cs_n |=> ($stable(dac_a) && $stable(dac_b)));

    a_r9_write_and_update: assert property (@(posedge clk) disable iff (!clr_n)
        (!cs_n && !upd_n && !wr_n) |=> ({dac_b, dac_a} == hold_q));

endmodule

bind dual_dac_loader dual_dac_loader_chk #(
    .DATA_W (DATA_W),
    .CODE_W (CODE_W)
) u_chk (.*);

// File: tb/dual_dac_loader_bench.sv
module dual_dac_loader_bench;

    localparam int DATA_W = 8;
    localparam int CODE_W = 12;

    logic              clk = 1'b0;
    logic              clr_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              wr_n = 1'b1;
    logic              upd_n = 1'b1;
    logic [1:0]        addr = '0;
    logic [DATA_W-1:0] data = '0;
    logic [CODE_W-1:0] dac_a;
    logic [CODE_W-1:0] dac_b;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [CODE_W-1:0] exp_hold [2];
    logic [CODE_W-1:0] exp_out  [2];

    dual_dac_loader #(
        .DATA_W (DATA_W),
        .CODE_W (CODE_W)
    ) u_dual_dac_loader (
        .clk   (clk),
        .clr_n (clr_n),
        .cs_n  (cs_n),
        .wr_n  (wr_n),
        .upd_n (upd_n),
        .addr  (addr),
        .data  (data),
        .dac_a (dac_a),
        .dac_b (dac_b)
    );

    always #5 clk = ~clk;

    task automatic check(string req, logic [CODE_W-1:0] act, logic [CODE_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outs(string req);
        check({req, " dac_a"}, dac_a, exp_out[0]);
        check({req, " dac_b"}, dac_b, exp_out[1]);
    endtask

    function automatic void model_write(logic [1:0] a, logic [7:0] d);
        if (a[0]) exp_hold[a[1]][11:8] = d[3:0];
        else      exp_hold[a[1]][7:0]  = d;
    endfunction

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; data = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        model_write(a, d);
    endtask

    task automatic bus_update();
        @(negedge clk);
        cs_n = 1'b0; upd_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; upd_n = 1'b1;
        exp_out = exp_hold;
    endtask

    task automatic t_reset();
        exp_hold = '{default: '0};
        exp_out  = '{default: '0};
        repeat (3) @(negedge clk);
        check("R1 reset", dac_a, '0);
        check("R1 reset", dac_b, '0);
        clr_n = 1'b1;
        @(negedge clk);
        bus_update();
        check_outs("R1 holding zero after reset");
    endtask

    task automatic t_shuffled(int seed);
        logic [1:0] order [4];
        logic [7:0] vals  [4];
        int dummy;
        dummy = $urandom(seed);
        for (int i = 0; i < 4; i++) begin
            order[i] = 2'(i);
            vals[i]  = 8'($urandom_range(255, 0));
        end
        for (int i = 3; i > 0; i--) begin
            int j;
            logic [1:0] tmp;
            j = $urandom_range(i, 0);
            tmp = order[i]; order[i] = order[j]; order[j] = tmp;
        end
        for (int i = 0; i < 4; i++) begin
            // High nibble writes carry set bits 7..4 that must be dropped (R3, R4)
            logic [7:0] d;
            d = order[i][0] ? (vals[i] | 8'hF0) : vals[i];
            bus_write(order[i], d);
            check_outs("R6 outputs held after write");
        end
        bus_update();
        check_outs("R2 R3 R4 R7 update after shuffled writes");
    endtask

    task automatic t_ignored_write();
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; data = 8'h5A;
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b1; addr = 2'd2; data = 8'hA5;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        bus_update();
        check_outs("R5 write without strobes ignored");
    endtask

    task automatic t_upd_no_cs();
        bus_write(2'd0, 8'h3C);
        bus_write(2'd3, 8'h09);
        @(negedge clk);
        cs_n = 1'b1; upd_n = 1'b0;
        @(negedge clk);
        upd_n = 1'b1;
        check_outs("R8 update with cs_n high ignored");
        bus_update();
        check_outs("R7 update after ignored one");
    endtask

    task automatic t_write_with_update();
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; upd_n = 1'b0; addr = 2'd1; data = 8'hF7;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; upd_n = 1'b1;
        model_write(2'd1, 8'hF7);
        exp_out = exp_hold;
        check_outs("R9 write and update on one edge");
    endtask

    task automatic t_held_write();
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'd2; data = 8'h11;
        @(negedge clk);
        data = 8'h22;
        @(negedge clk);
        data = 8'hE3;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; data = 8'h44;
        model_write(2'd2, 8'hE3);
        check_outs("R6 outputs held during held write");
        bus_update();
        check_outs("R10 last value of held write kept");
    endtask

    task automatic t_async_clear();
        bus_write(2'd0, 8'hFF);
        bus_write(2'd3, 8'h0F);
        bus_update();
        @(negedge clk);
        #2 clr_n = 1'b0;
        #1;
        exp_hold = '{default: '0};
        exp_out  = '{default: '0};
        check_outs("R1 clear acts without clock");
        @(negedge clk);
        clr_n = 1'b1;
        bus_update();
        check_outs("R1 holding words cleared");
    endtask

    initial begin
        t_reset();
        t_shuffled(7);
        t_shuffled(1234);
        t_ignored_write();
        t_upd_no_cs();
        t_write_with_update();
        t_held_write();
        t_async_clear();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule